// File: doc/BRIEF.md
# Machine Status Register Legalizer

This block holds the 64-bit machine status register of a RISC-V style hart. Every write is cleaned up before it is stored. Undefined bits are dropped. The extension-context status field is pinned to Off. Fields that the configured capabilities do not support are cleared. The summary dirty bit is recomputed from the three extension-status fields. The register-width fields are never allowed to change.

A second, supervisor-level view shares the same storage. Reads through this view expose only a subset of the fields. Writes through it can change only the supervisor-owned fields, and the merged result then goes through the same cleanup as a machine write.

The block also works out the privilege level that data accesses run at. When the modify-privilege bit is set, any access that is not an instruction fetch uses the previous-machine-privilege field in place of the current privilege.

Top module: `msr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the register clears to zero, except bits 35:32 (supervisor and user width codes), which both load the 64-bit code 2'b10. This gives a machine read of 64'h0000_000A_0000_0000.
- R2: A machine-view write (`wr_view`=0) stores only write-data bits 22..7, 5..3 and 1..0. Bits 6, 2, 62:38 and 31:23 always read as zero.
- R3: Extension-status codes are Off=2'b00, Initial=2'b01, Clean=2'b10, Dirty=2'b11. Any write leaves bits 16:15 (extension context) at Off.
- R4: When `cap_finx` is 1, any write leaves bits 14:13 (float status) at Off. Otherwise those bits take the written value.
- R5: Every write recomputes bit 63. It is 1 exactly when bits 14:13, 16:15 or 10:9 (vector status) hold Dirty.
- R6: Writes never change bits 35:32. Bits 37:36 always read as zero.
- R7: With `cap_next`=0, a write clears bit 4 (user previous interrupt enable) and bit 0 (user interrupt enable). With `cap_user`=0, a write clears bit 17 (modify privilege).
- R8: `rd_sup` shows bits 63, 33:32, 19, 18, 16:15, 14:13, 10:9, 8, 5, 4, 1 and 0 of the register, with every other bit zero.
- R9: A supervisor-view write (`wr_view`=1) replaces only bits 19, 18, 16:15, 14:13, 10:9, 8, 5, 4, 1 and 0 from the write data. All other bits keep their old value, and R2 to R7 then apply to the merged value.
- R10: `eff_priv` equals bits 12:11 (previous machine privilege) when `acc_is_fetch`=0 and bit 17 is 1. Otherwise it equals `cur_priv`. Privilege codes are user 2'b00, supervisor 2'b01 and machine 2'b11.
- R11: The register keeps its value in any cycle where `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_view | input | 1 | 0 selects the machine view, 1 selects the supervisor view |
| wr_data | input | 64 | Write data |
| cap_user | input | 1 | User mode is present |
| cap_next | input | 1 | User-level interrupt extension is present |
| cap_finx | input | 1 | Float-in-integer-register mode, so no float status |
| acc_is_fetch | input | 1 | The current access is an instruction fetch |
| cur_priv | input | 2 | Current privilege level |
| rd_mach | output | 64 | Machine-view read data |
| rd_sup | output | 64 | Supervisor-view read data |
| eff_priv | output | 2 | Effective privilege for the access |

## Verification
The bench builds the block with its default parameters: a 64-bit register and a reset width code of 2'b10. As a result, the width fields hold a non-zero pattern, so any write that disturbed them would be visible. Because the capability inputs are ports, the bench can change them from write to write. This lets one run reach the combinations that clear the user-interrupt fields, the modify-privilege bit and the float status, each through both views. Pseudo-random writes, mixed with directed all-ones and all-zeros patterns, reach both Dirty and non-Dirty status combinations for the summary bit.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int XLEN = 64;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        EXT_OFF   = 2'b00,
        EXT_INIT  = 2'b01,
        EXT_CLEAN = 2'b10,
        EXT_DIRTY = 2'b11
    } ext_stat_e;

    typedef struct packed {
        logic has_user;
        logic has_next;
        logic finx;
    } caps_t;

    // field positions
    localparam int B_UIE   = 0;
    localparam int B_SIE   = 1;
    localparam int B_MIE   = 3;
    localparam int B_UPIE  = 4;
    localparam int B_SPIE  = 5;
    localparam int B_MPIE  = 7;
    localparam int B_SPP   = 8;
    localparam int B_VS    = 9;
    localparam int B_MPP   = 11;
    localparam int B_FS    = 13;
    localparam int B_XS    = 15;
    localparam int B_MPRV  = 17;
    localparam int B_SUM   = 18;
    localparam int B_MXR   = 19;
    localparam int B_UXL   = 32;
    localparam int B_SXL   = 34;
    localparam int B_ENDN  = 36;
    localparam int B_SD    = XLEN - 1;

    function automatic word_t span(input int hi, input int lo);
        word_t m;
        m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam word_t KEEP_MASK = span(22, 7) | span(5, 3) | span(1, 0);

    localparam word_t SUP_WR_MASK =
        span(B_MXR, B_MXR) | span(B_SUM, B_SUM) | span(B_XS+1, B_XS) |
        span(B_FS+1, B_FS) | span(B_VS+1, B_VS) | span(B_SPP, B_SPP) |
        span(B_SPIE, B_SPIE) | span(B_UPIE, B_UPIE) |
        span(B_SIE, B_SIE) | span(B_UIE, B_UIE);

    localparam word_t SUP_RD_MASK =
        SUP_WR_MASK | span(B_SD, B_SD) | span(B_UXL+1, B_UXL);

    function automatic logic any_dirty(input logic [1:0] a,
                                       input logic [1:0] b,
                                       input logic [1:0] c);
        return (a == EXT_DIRTY) || (b == EXT_DIRTY) || (c == EXT_DIRTY);
    endfunction

endpackage

// File: rtl/msr_legalize.sv
module msr_legalize
    import msr_pkg::*;
(
    input  word_t old_val,
    input  word_t wr_val,
    input  logic  sup_view,
    input  caps_t caps,
    output word_t new_val
);
    word_t merged;
    word_t n;

    always_comb begin
        if (sup_view) merged = (old_val & ~SUP_WR_MASK) | (wr_val & SUP_WR_MASK);
        else          merged = wr_val;

        n = merged & KEEP_MASK;
        n[B_XS+1:B_XS] = EXT_OFF;
        if (caps.finx) n[B_FS+1:B_FS] = EXT_OFF;
        if (!caps.has_next) begin
            n[B_UPIE] = 1'b0;
            n[B_UIE]  = 1'b0;
        end
        if (!caps.has_user) n[B_MPRV] = 1'b0;
        n[B_SXL+1:B_UXL]  = old_val[B_SXL+1:B_UXL];
        n[B_ENDN+1:B_ENDN] = 2'b00;
        n[B_SD] = any_dirty(n[B_FS+1:B_FS], n[B_XS+1:B_XS], n[B_VS+1:B_VS]);
        new_val = n;
    end
endmodule

// File: rtl/msr_supview.sv
module msr_supview
    import msr_pkg::*;
(
    input  word_t mach_val,
    output word_t sup_val
);
    assign sup_val = mach_val & SUP_RD_MASK;
endmodule

// File: rtl/msr_effpriv.sv
module msr_effpriv (
    input  logic       is_fetch,
    input  logic [1:0] cur_priv,
    input  logic       mprv,
    input  logic [1:0] mpp,
    output logic [1:0] eff_priv
);
    always_comb begin
        if (!is_fetch && mprv) eff_priv = mpp;
        else                   eff_priv = cur_priv;
    end
endmodule

// File: rtl/msr_unit.sv
module msr_unit
    import msr_pkg::*;
#(
    parameter logic [1:0] RESET_XL = 2'b10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       wr_view,
    input  logic [msr_pkg::XLEN-1:0]   wr_data,
    input  logic                       cap_user,
    input  logic                       cap_next,
    input  logic                       cap_finx,
    input  logic                       acc_is_fetch,
    input  logic [1:0]                 cur_priv,
    output logic [msr_pkg::XLEN-1:0]   rd_mach,
    output logic [msr_pkg::XLEN-1:0]   rd_sup,
    output logic [1:0]                 eff_priv
);
    localparam word_t RESET_VAL =
        word_t'({RESET_XL, RESET_XL}) << B_UXL;

    word_t  state_q;
    word_t  legal_d;
    caps_t  caps;

    assign caps = '{has_user: cap_user, has_next: cap_next, finx: cap_finx};

    msr_legalize legal_i (
        .old_val  (state_q),
        .wr_val   (wr_data),
        .sup_view (wr_view),
        .caps     (caps),
        .new_val  (legal_d)
    );

    always_ff @(posedge clk) begin
        if (rst)        state_q <= RESET_VAL;
        else if (wr_en) state_q <= legal_d;
    end

    msr_supview view_i (
        .mach_val (state_q),
        .sup_val  (rd_sup)
    );

    msr_effpriv priv_i (
        .is_fetch (acc_is_fetch),
        .cur_priv (cur_priv),
        .mprv     (state_q[B_MPRV]),
        .mpp      (state_q[B_MPP+1:B_MPP]),
        .eff_priv (eff_priv)
    );

    assign rd_mach = state_q;
endmodule

// File: rtl/msr_unit_chk.sv
module msr_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        wr_view,
    input logic        cap_user,
    input logic        cap_next,
    input logic        cap_finx,
    input logic        acc_is_fetch,
    input logic [1:0]  cur_priv,
    input logic [63:0] rd_mach,
    input logic [63:0] rd_sup,
    input logic [1:0]  eff_priv
);
    // R2
    undefined_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_mach[6] == 1'b0) && (rd_mach[2] == 1'b0) && (rd_mach[62:38] == '0) && (rd_mach[31:23] == '0));

    // R3
    xs_off_chk: assert property (@(posedge clk) disable iff (rst)
        rd_mach[16:15] == 2'b00);

    // R4
    finx_fs_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cap_finx) |=> (rd_mach[14:13] == 2'b00));

    // R5
    sd_summary_chk: assert property (@(posedge clk) disable iff (rst)
        rd_mach[63] == ((rd_mach[14:13] == 2'b11) || (rd_mach[16:15] == 2'b11) || (rd_mach[10:9] == 2'b11)));

    // R6
    width_stable_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ($stable(rd_mach[35:32]) && (rd_mach[37:36] == 2'b00)));

    // R7
    no_next_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cap_next) |=> (rd_mach[4] == 1'b0 && rd_mach[0] == 1'b0));

    // R7
    no_user_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cap_user) |=> (rd_mach[17] == 1'b0));

    // R8
    sup_sd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_sup[63] == rd_mach[63]) && (rd_sup[62:34] == '0) && (rd_sup[12:11] == 2'b00) && (rd_sup[3] == 1'b0));

    // R9
    sup_keeps_mach_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view) |=> ($stable(rd_mach[12:11]) && $stable(rd_mach[3]) && $stable(rd_mach[7]) && $stable(rd_mach[22:20])));

    // R10
    eff_mpp_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_is_fetch && rd_mach[17]) |-> (eff_priv == rd_mach[12:11]));

    // R10
    eff_cur_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_is_fetch || !rd_mach[17]) |-> (eff_priv == cur_priv));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_mach));
endmodule

bind msr_unit msr_unit_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_view      (wr_view),
    .cap_user     (cap_user),
    .cap_next     (cap_next),
    .cap_finx     (cap_finx),
    .acc_is_fetch (acc_is_fetch),
    .cur_priv     (cur_priv),
    .rd_mach      (rd_mach),
    .rd_sup       (rd_sup),
    .eff_priv     (eff_priv)
);

// File: tb/msr_unit_tb_top.sv
module msr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_view = 1'b0;
    logic [63:0] wr_data = '0;
    logic        cap_user = 1'b1;
    logic        cap_next = 1'b1;
    logic        cap_finx = 1'b0;
    logic        acc_is_fetch = 1'b0;
    logic [1:0]  cur_priv = 2'b11;
    logic [63:0] rd_mach;
    logic [63:0] rd_sup;
    logic [1:0]  eff_priv;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [63:0] mdl;

    always #5 clk = ~clk;

    msr_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_view(wr_view), .wr_data(wr_data),
        .cap_user(cap_user), .cap_next(cap_next), .cap_finx(cap_finx),
        .acc_is_fetch(acc_is_fetch), .cur_priv(cur_priv),
        .rd_mach(rd_mach), .rd_sup(rd_sup), .eff_priv(eff_priv)
    );

    // behavioural reference: build the new value field by field
    function automatic logic [63:0] ref_write(input logic [63:0] old, input logic [63:0] v,
                                              input logic sup, input logic usr,
                                              input logic nxt, input logic fx);
        logic [63:0] r;
        logic [63:0] src;
        src = sup ? old : v;
        if (sup) begin
            src[19] = v[19]; src[18] = v[18]; src[16:15] = v[16:15];
            src[14:13] = v[14:13]; src[10:9] = v[10:9]; src[8] = v[8];
            src[5] = v[5]; src[4] = v[4]; src[1] = v[1]; src[0] = v[0];
        end
        r = '0;
        r[22:17] = src[22:17];
        r[14:7]  = src[14:7];
        r[5:3]   = src[5:3];
        r[1:0]   = src[1:0];
        if (fx)   r[14:13] = 2'b00;
        if (!nxt) begin r[4] = 1'b0; r[0] = 1'b0; end
        if (!usr) r[17] = 1'b0;
        r[35:32] = old[35:32];
        r[63] = (r[14:13] == 2'b11) | (r[10:9] == 2'b11);
        return r;
    endfunction

    function automatic logic [63:0] ref_sup(input logic [63:0] m);
        logic [63:0] s;
        s = '0;
        s[63] = m[63]; s[33:32] = m[33:32]; s[19:18] = m[19:18];
        s[16:13] = m[16:13]; s[10:8] = m[10:8]; s[5:4] = m[5:4]; s[1:0] = m[1:0];
        return s;
    endfunction

    always @(posedge clk) begin
        if (rst)        mdl <= 64'h0000_000A_0000_0000;
        else if (wr_en) mdl <= ref_write(mdl, wr_data, wr_view, cap_user, cap_next, cap_finx);
    end

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // advance one clock; compare everything against the model at the falling edge
    task automatic step();
        logic [1:0] e;
        @(posedge clk);
        @(negedge clk);
        e = (!acc_is_fetch && mdl[17]) ? mdl[12:11] : cur_priv;
        chk64("R2/R9 model rd_mach", rd_mach, mdl);
        chk64("R8 model rd_sup", rd_sup, ref_sup(mdl));
        chk64("R10 model eff_priv", {62'd0, eff_priv}, {62'd0, e});
    endtask

    task automatic wr(input logic view, input logic [63:0] d);
        wr_en = 1'b1; wr_view = view; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] lf;
        step(); step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk64("R1 reset rd_mach", rd_mach, 64'h0000_000A_0000_0000);
        chk64("R8 reset rd_sup", rd_sup, 64'h0000_0002_0000_0000);
        chk64("R10 reset eff_priv", {62'd0, eff_priv}, 64'd3);

        // R2 R3 R5 R6: all ones through machine view
        wr(1'b0, '1);
        chk64("R2 R3 R5 R6 ones", rd_mach, 64'h8000_000A_007E_7FBB);

        // R4 finx
        cap_finx = 1'b1;
        wr(1'b0, '1);
        chk64("R4 finx clears FS", rd_mach, 64'h8000_000A_007E_1FBB);
        cap_finx = 1'b0;

        // R5 no dirty, MPP=machine, MPRV set
        wr(1'b0, 64'h0000_0000_0002_1800);
        chk64("R5 clean SD low", rd_mach, 64'h0000_000A_0002_1800);
        acc_is_fetch = 1'b0; cur_priv = 2'b00;
        step();
        chk64("R10 data uses MPP", {62'd0, eff_priv}, 64'd3);
        acc_is_fetch = 1'b1;
        step();
        chk64("R10 fetch uses current", {62'd0, eff_priv}, 64'd0);
        acc_is_fetch = 1'b0;

        // R7 no user, no N
        cap_user = 1'b0; cap_next = 1'b0;
        wr(1'b0, '1);
        chk64("R7 cleared fields", rd_mach, 64'h8000_000A_007C_7FAA);
        chk64("R8 supervisor read", rd_sup, 64'h8000_0002_000C_6722);
        cap_user = 1'b1; cap_next = 1'b1;

        // R9 supervisor writes
        wr(1'b1, '0);
        chk64("R9 sup zeros", rd_mach, 64'h0000_000A_0070_1888);
        wr(1'b1, '1);
        chk64("R9 sup ones", rd_mach, 64'h8000_000A_007C_7FBB);

        // R11 hold
        wr_en = 1'b0; wr_data = 64'h1234_5678_9ABC_DEF0;
        step(); step();
        chk64("R11 hold", rd_mach, 64'h8000_000A_007C_7FBB);

        // pseudo-random mix
        lf = 64'hACE1_2345_6789_BEEF;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            wr_en = lf[3]; wr_view = lf[7]; wr_data = lf ^ {lf[31:0], lf[63:32]};
            cap_user = lf[11]; cap_next = lf[13]; cap_finx = lf[17] & lf[19];
            acc_is_fetch = lf[23]; cur_priv = lf[26:25];
            step();
        end
        wr_en = 1'b0;
        step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule